// File: doc/BRIEF.md
# Bartlett Averaging and Decimating Filter

This block smooths and thins a stream of 16-bit signed samples. Every accepted sample first passes through two identical moving-average stages. Each stage averages the most recent 2^B results, and the two in series give a triangular (Bartlett) impulse response. The second stage's results are then grouped into blocks of 2^D. Each block produces one averaged output and a data-ready strobe.

No precision is lost in the block average. The result is presented as a 32-bit word whose upper half is the ordinary 16-bit reading and whose lower half carries the fractional bits that the averaging adds, justified toward the top. A signed 32-bit correction is added to that word, and the total is clamped to the signed 32-bit range. Writing the tap and block settings restarts the filter from an empty history.

Top module: `bartlett_decim_filter`

## Requirements
- R1: After reset, out_main and out_ext are 0x0000, out_drdy is at its inactive level, and both B and D are 0, so samples pass straight through.
- R2: Each averaging stage outputs floor(S / 2^B), where S is the sum of its last 2^B accepted inputs. History from before the last reset or setting write counts as zero. The second stage takes the first stage's outputs as its inputs.
- R3: A B code above 6 (the value 7) behaves exactly as B = 6, and a D code above 16 behaves as D = 16.
- R4: With D in 0..16, exactly one output is produced for every 2^D accepted second-stage results, and no output is produced for a partial block.
- R5: The output word is W = (sum of the block) × 2^(16−D). out_main is W[31:16] and out_ext is W[15:0], so the low 16−D bits of out_ext are zero when the correction is zero.
- R6: With B = 0 and D = 0, every accepted sample produces one output whose out_main equals the sample and whose out_ext is 0x0000 (with a zero correction).
- R7: The signed 32-bit correction {offset_main, offset_ext} is added to W before the output is split into its two halves.
- R8: If W plus the correction exceeds 0x7FFFFFFF, the output is 0x7FFF/0xFFFF. If it falls below −2^31, the output is 0x8000/0x0000.
- R9: out_drdy is active for exactly one clock for each new output. When drdy_active_high = 1 it idles at 0 and pulses to 1; when it is 0 it idles at 1 and pulses to 0.
- R10: A clock with cfg_we = 1 loads B and D and clears all history, running sums, in-flight samples and any partial block. A sample presented in that same clock is discarded.
- R11: Clocks with in_valid = 0 change nothing: idle gaps between samples do not alter any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load B and D, and restart the filter |
| cfg_taps_log2 | input | 3 | B: log2 of the taps per averaging stage |
| cfg_dec_log2 | input | 5 | D: log2 of the block length |
| drdy_active_high | input | 1 | Polarity of out_drdy |
| offset_main | input | 16 | Upper half of the signed correction |
| offset_ext | input | 16 | Lower half of the signed correction |
| in_valid | input | 1 | in_sample is accepted this clock |
| in_sample | input | 16 | Signed input sample |
| out_main | output | 16 | Signed averaged output, upper half |
| out_ext | output | 16 | Extra-resolution bits, lower half |
| out_drdy | output | 1 | One-clock data-ready strobe |

## Verification
The assertions assume three things about the inputs. The correction inputs stay steady while a block is in flight. The settings change only through a cfg_we clock. A sample arriving with cfg_we is treated as lost. The stimulus keeps to these by changing the correction and polarity only after the pipeline has been idle for several clocks, and by letting outputs drain before each setting write. One write deliberately presents a sample in the write clock to show that the sample is dropped.

// File: rtl/bdf_pkg.sv
package bdf_pkg;
  localparam int unsigned TAPS_SEL_W = 3;
  localparam int unsigned DEC_SEL_W  = 5;

  typedef int unsigned uint_t;
  typedef logic [TAPS_SEL_W-1:0] taps_sel_t;
  typedef logic [DEC_SEL_W-1:0]  dec_sel_t;

  typedef struct packed {
    taps_sel_t taps_log2;
    dec_sel_t  dec_log2;
  } filt_cfg_t;

  // Limit a requested setting to its largest supported value
  function automatic uint_t clamp_sel(input uint_t v, input uint_t lim);
    return (v > lim) ? lim : v;
  endfunction
endpackage

// File: rtl/bdf_boxcar.sv
module bdf_boxcar #(
  parameter int unsigned W       = 16,
  parameter int unsigned MAX_LOG = 6,
  parameter int unsigned SEL_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [SEL_W-1:0]    taps_log2,
  input  logic                in_v,
  input  logic signed [W-1:0] in_d,
  output logic                out_v,
  output logic signed [W-1:0] out_d
);
  localparam int unsigned DEPTH = 1 << MAX_LOG;
  localparam int unsigned AW    = MAX_LOG;
  localparam int unsigned SUM_W = W + MAX_LOG + 1;

  logic signed [W-1:0]     ring [DEPTH];
  logic [AW-1:0]           wp;
  logic [AW-1:0]           oldest_idx;
  logic signed [SUM_W-1:0] acc;
  logic signed [SUM_W-1:0] acc_nxt;

  // Entry written 2^B pushes ago; at the full depth it is the slot about to be reused
  assign oldest_idx = wp - AW'((AW+1)'(1) << taps_log2);
  assign acc_nxt    = acc + SUM_W'(in_d) - SUM_W'(ring[oldest_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int i = 0; i < int'(DEPTH); i++) ring[i] <= '0;
      wp    <= '0;
      acc   <= '0;
      out_v <= 1'b0;
      out_d <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) begin
        ring[wp] <= in_d;
        wp       <= wp + 1'b1;
        acc      <= acc_nxt;
        out_d    <= W'(acc_nxt >>> taps_log2);
      end
    end
  end

  // A restart leaves an empty sum and nothing in flight
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (acc == '0 && !out_v));

  // An idle clock leaves the running sum untouched
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_v && !flush) |=> $stable(acc));
endmodule

// File: rtl/bdf_decim.sv
module bdf_decim #(
  parameter int unsigned W       = 16,
  parameter int unsigned MAX_LOG = 16,
  parameter int unsigned SEL_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [SEL_W-1:0]    dec_log2,
  input  logic                in_v,
  input  logic signed [W-1:0] in_d,
  input  logic [2*W-1:0]      offset,
  output logic [2*W-1:0]      word_q,
  output logic                done
);
  localparam int unsigned OUT_W  = 2 * W;
  localparam int unsigned ACC_W  = W + MAX_LOG + 1;
  localparam int unsigned WIDE_W = OUT_W + 2;
  localparam int unsigned CNT_W  = MAX_LOG + 1;

  // Place the block sum so that its fractional bits sit just under bit W
  function automatic logic signed [WIDE_W-1:0] justify(
    input logic signed [ACC_W-1:0] s, input int unsigned d);
    logic signed [WIDE_W-1:0] w;
    w = WIDE_W'(s);
    return w <<< (W - d);
  endfunction

  // Clamp a wide signed value into the signed OUT_W range
  function automatic logic [OUT_W-1:0] clip(input logic signed [WIDE_W-1:0] v);
    logic [2:0] top;
    top = v[WIDE_W-1:OUT_W-1];
    if (top == 3'b000 || top == 3'b111) return v[OUT_W-1:0];
    else if (v[WIDE_W-1])               return {1'b1, {(OUT_W-1){1'b0}}};
    else                                return {1'b0, {(OUT_W-1){1'b1}}};
  endfunction

  logic [CNT_W-1:0]         cnt;
  logic [CNT_W-1:0]         last_idx;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  acc_nxt;
  logic signed [WIDE_W-1:0] total;
  logic                     blk_end;

  assign last_idx = CNT_W'((1 << dec_log2) - 1);
  assign acc_nxt  = acc + ACC_W'(in_d);
  assign blk_end  = in_v && (cnt == last_idx);
  assign total    = justify(acc_nxt, int'(dec_log2)) + WIDE_W'($signed(offset));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      acc    <= '0;
      done   <= 1'b0;
      word_q <= '0;
    end else if (flush) begin
      cnt  <= '0;
      acc  <= '0;
      done <= 1'b0;
    end else begin
      done <= blk_end;
      if (blk_end) begin
        word_q <= clip(total);
        acc    <= '0;
        cnt    <= '0;
      end else if (in_v) begin
        acc <= acc_nxt;
        cnt <= cnt + 1'b1;
      end
    end
  end

  // The position inside a block never passes the block length
  p_cnt_in_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_idx);

  // Every finished output traces back to an accepted sample
  p_done_from_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_v));

  // A block length of one turns every sample into an output
  p_pass_each_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_log2 == '0 && in_v && !flush) |=> done);

  // Blocks of two or more samples cannot finish in consecutive clocks
  p_drdy_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dec_log2 != '0) |=> !done);

  // A restart abandons the partial block
  p_flush_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0 && !done));
endmodule

// File: rtl/bartlett_decim_filter.sv
module bartlett_decim_filter
  import bdf_pkg::*;
#(
  parameter int unsigned SAMPLE_W     = 16,
  parameter int unsigned TAPS_LOG_MAX = 6,
  parameter int unsigned DEC_LOG_MAX  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [TAPS_SEL_W-1:0] cfg_taps_log2,
  input  logic [DEC_SEL_W-1:0]  cfg_dec_log2,
  input  logic                  drdy_active_high,
  input  logic [SAMPLE_W-1:0]   offset_main,
  input  logic [SAMPLE_W-1:0]   offset_ext,
  input  logic                  in_valid,
  input  logic [SAMPLE_W-1:0]   in_sample,
  output logic [SAMPLE_W-1:0]   out_main,
  output logic [SAMPLE_W-1:0]   out_ext,
  output logic                  out_drdy
);
  localparam int unsigned N_STAGES = 2;
  localparam int unsigned OUT_W    = 2 * SAMPLE_W;

  filt_cfg_t                  cfg_q;
  logic                       stg_v [N_STAGES+1];
  logic signed [SAMPLE_W-1:0] stg_d [N_STAGES+1];
  logic [OUT_W-1:0]           word_q;
  logic                       dec_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q.taps_log2 <= TAPS_SEL_W'(clamp_sel(uint_t'(cfg_taps_log2), TAPS_LOG_MAX));
      cfg_q.dec_log2  <= DEC_SEL_W'(clamp_sel(uint_t'(cfg_dec_log2), DEC_LOG_MAX));
    end
  end

  assign stg_v[0] = in_valid;
  assign stg_d[0] = in_sample;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_avg
    bdf_boxcar #(
      .W       (SAMPLE_W),
      .MAX_LOG (TAPS_LOG_MAX),
      .SEL_W   (TAPS_SEL_W)
    ) u_avg (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (cfg_we),
      .taps_log2 (cfg_q.taps_log2),
      .in_v      (stg_v[s]),
      .in_d      (stg_d[s]),
      .out_v     (stg_v[s+1]),
      .out_d     (stg_d[s+1])
    );
  end

  bdf_decim #(
    .W       (SAMPLE_W),
    .MAX_LOG (DEC_LOG_MAX),
    .SEL_W   (DEC_SEL_W)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (cfg_we),
    .dec_log2 (cfg_q.dec_log2),
    .in_v     (stg_v[N_STAGES]),
    .in_d     (stg_d[N_STAGES]),
    .offset   ({offset_main, offset_ext}),
    .word_q   (word_q),
    .done     (dec_done)
  );

  assign out_main = word_q[OUT_W-1:SAMPLE_W];
  assign out_ext  = word_q[SAMPLE_W-1:0];
  assign out_drdy = drdy_active_high ? dec_done : !dec_done;

  // Stored settings never exceed the supported maxima
  p_cfg_capped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uint_t'(cfg_q.taps_log2) <= TAPS_LOG_MAX) && (uint_t'(cfg_q.dec_log2) <= DEC_LOG_MAX));
endmodule

// File: tb/bartlett_decim_filter_tb.sv
`timescale 1ns/1ps
module bartlett_decim_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_taps_log2 = '0;
  logic [4:0]  cfg_dec_log2 = '0;
  logic        drdy_active_high = 1'b1;
  logic [15:0] offset_main = '0;
  logic [15:0] offset_ext = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic [15:0] out_main;
  logic [15:0] out_ext;
  logic        out_drdy;

  always #2 clk = ~clk;

  bartlett_decim_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_taps_log2(cfg_taps_log2),
    .cfg_dec_log2(cfg_dec_log2), .drdy_active_high(drdy_active_high),
    .offset_main(offset_main), .offset_ext(offset_ext), .in_valid(in_valid),
    .in_sample(in_sample), .out_main(out_main), .out_ext(out_ext), .out_drdy(out_drdy));

  int    chk_cnt = 0, chk_bad = 0, mon_cmp = 0, mon_bad = 0, wd_bad = 0;
  string cur_req = "R1";
  logic [31:0] exp_q[$];

  // Reference model state
  int     mb = 0, md = 0;
  longint h1[$], h2[$];
  longint dsum = 0;
  int     dcnt = 0;

  function automatic longint floor_div(longint s, longint n);
    longint r = s % n;
    if (r < 0) r += n;
    return (s - r) / n;
  endfunction

  function automatic longint stage_avg(ref longint h[$], input int b);
    longint s = 0;
    for (int i = 0; i < (1 << b); i++) if (i < h.size()) s += h[i];
    return floor_div(s, longint'(1) << b);
  endfunction

  task automatic model_reset(int b, int d);
    mb = (b > 6) ? 6 : b;
    md = (d > 16) ? 16 : d;
    h1.delete(); h2.delete();
    dsum = 0; dcnt = 0;
  endtask

  task automatic model_push(longint x);
    longint y1, y2, w, off;
    h1.push_front(x); if (h1.size() > 64) void'(h1.pop_back());
    y1 = stage_avg(h1, mb);
    h2.push_front(y1); if (h2.size() > 64) void'(h2.pop_back());
    y2 = stage_avg(h2, mb);
    dsum += y2; dcnt++;
    if (dcnt == (1 << md)) begin
      off = longint'($signed({offset_main, offset_ext}));
      w = dsum * (longint'(1) << (16 - md)) + off;
      if (w > 64'sd2147483647) w = 64'sd2147483647;
      if (w < -64'sd2147483648) w = -64'sd2147483648;
      exp_q.push_back(w[31:0]);
      dsum = 0; dcnt = 0;
    end
  endtask

  // Driver: present one sample for one clock and predict its effect
  task automatic send(logic [15:0] x);
    in_valid = 1'b1; in_sample = x;
    model_push(longint'($signed(x)));
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic write_cfg(int b, int d, bit with_sample);
    cfg_we = 1'b1; cfg_taps_log2 = 3'(b); cfg_dec_log2 = 5'(d);
    if (with_sample) begin in_valid = 1'b1; in_sample = 16'h7777; end
    model_reset(b, d);
    @(posedge clk); #1;
    cfg_we = 1'b0; in_valid = 1'b0;
  endtask

  task automatic check(string req, string what, longint act, longint exp);
    chk_cnt++;
    if (act != exp) begin
      chk_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drain(string req);
    idle(6);
    check(req, "pending outputs after drain", exp_q.size(), 0);
  endtask

  // Monitor: compare each strobe against the scoreboard
  always @(negedge clk) begin
    if (rst_n && (out_drdy === drdy_active_high)) begin
      mon_cmp++;
      if (exp_q.size() == 0) begin
        mon_bad++;
        $display("FAIL %s unexpected output: actual %h_%h expected none", cur_req, out_main, out_ext);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if ({out_main, out_ext} !== e) begin
          mon_bad++;
          $display("FAIL %s output word: actual %h_%h expected %h_%h",
                   cur_req, out_main, out_ext, e[31:16], e[15:0]);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    wd_bad = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             chk_cnt + mon_cmp + 1, chk_bad + mon_bad + 1);
    $finish;
  end

  initial begin
    model_reset(0, 0);
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: reset state
    cur_req = "R1";
    check("R1", "out_main after reset", out_main, 0);
    check("R1", "out_ext after reset", out_ext, 0);
    check("R1", "out_drdy idle after reset", out_drdy, 0);
    send(16'h1234);
    send(16'h8001);
    drain("R1");

    // R6 and R11: pass-through with idle gaps
    cur_req = "R6";
    for (int i = 0; i < 24; i++) begin
      send(16'($urandom));
      if (i % 3 == 0) idle(1 + (i % 4));
    end
    drain("R6");

    // R2: four taps per stage, step and random input
    cur_req = "R2";
    idle(4); write_cfg(2, 0, 0);
    for (int i = 0; i < 10; i++) send(16'h1000);
    for (int i = 0; i < 10; i++) send(-16'sd300);
    for (int i = 0; i < 30; i++) send(16'($urandom));
    drain("R2");

    // R3: code 7 behaves as 64 taps
    cur_req = "R3";
    idle(4); write_cfg(7, 0, 0);
    for (int i = 0; i < 140; i++) send((i % 5 == 0) ? 16'h8000 : 16'($urandom));
    for (int i = 0; i < 70; i++) send(16'h7FFF);
    drain("R3");

    // R5 and R4: block of eight with fractional bits
    cur_req = "R5";
    idle(4); write_cfg(0, 3, 0);
    send(16'd1); send(16'd2);
    for (int i = 0; i < 6; i++) send(16'd0);
    for (int i = 0; i < 64; i++) send(16'($urandom));
    drain("R5");

    // R11 and R4: two taps, block of four, irregular gaps
    cur_req = "R11";
    idle(4); write_cfg(1, 2, 0);
    for (int i = 0; i < 48; i++) begin
      send(16'($urandom));
      idle($urandom_range(0, 3));
    end
    drain("R11");

    // R7: correction added into the 32-bit word
    cur_req = "R7";
    idle(4); offset_main = 16'h0010; offset_ext = 16'h8000;
    write_cfg(0, 1, 0);
    for (int i = 0; i < 16; i++) send(16'($urandom));
    send(16'hFFFF); send(16'hFFFE);
    drain("R7");

    // R8: saturation in both directions
    cur_req = "R8";
    idle(4); offset_main = 16'h7FFF; offset_ext = 16'h0000;
    write_cfg(0, 0, 0);
    send(16'h0000); send(16'h0001); send(16'h7FFF);
    idle(6); offset_main = 16'h8000;
    send(16'hFFFF); send(16'h8000); send(16'h0001);
    drain("R8");
    offset_main = 16'h0000;

    // R9: low-active strobe
    cur_req = "R9";
    idle(4); drdy_active_high = 1'b0;
    idle(1);
    check("R9", "out_drdy idle level when active-low", out_drdy, 1);
    for (int i = 0; i < 6; i++) send(16'($urandom));
    drain("R9");
    check("R9", "out_drdy returns to idle level", out_drdy, 1);
    drdy_active_high = 1'b1;

    // R10: restart drops a partial block and the sample in the write clock
    cur_req = "R10";
    idle(4); write_cfg(3, 2, 0);
    for (int i = 0; i < 5; i++) send(16'h0400);
    idle(4);
    exp_q.delete();
    write_cfg(3, 2, 1);
    for (int i = 0; i < 4; i++) send(16'h0800);
    for (int i = 0; i < 12; i++) send(16'($urandom));
    drain("R10");

    // R4: longest block, alternating 0 and 1 gives a half-LSB mean
    cur_req = "R4";
    idle(4); write_cfg(0, 16, 0);
    for (int i = 0; i < 65536; i++) send(16'(i % 2));
    drain("R4");
    check("R4", "outputs seen over whole run", (mon_cmp > 0) ? 1 : 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             chk_cnt + mon_cmp, chk_bad + mon_bad + wd_bad);
    $finish;
  end
endmodule